// File: doc/BRIEF.md
# Immediate ALU and Single-Step Shifter with Zero Flag

This block is the execute stage of a small 8-bit input/output controller core. Each cycle it can take one operation. The operation brings a register operand, an 8-bit immediate, an operation code and the 3-bit shift count field of the instruction. The block computes the value to write back to the register file and raises a write strobe when that value must be stored. It also keeps a one-bit condition flag that the branch logic reads. That flag means both "result was zero" and "compare found equality".

The operations are XOR, OR, AND and add with the immediate, and a compare that only touches the flag. There are also six one-position shifts and rotates: logical left, logical right, arithmetic left, arithmetic right and the two rotates. Arithmetic right shift fills the top bit with a constant 1 and does not copy the sign. OR with a zero immediate is the core's no-operation, so it neither writes nor touches the flag. A shift whose count field is not 1 is rejected, and so is an unassigned operation code.

The result path is combinational from the inputs. Only the flag is a register, and it is updated at the clock edge that ends the operation.

Top module: `imm_alu_unit`

## Requirements
- R1: After reset the flag output is 0. While op_valid is low, wr_en and illegal are 0 and the flag holds its value across clock edges.
- R2: The operation codes 0 (XOR), 1 (OR), 2 (AND) and 3 (add) combine reg_in with imm, present the result on wr_data and raise wr_en in the same cycle. Add wraps modulo 256 and produces no carry.
- R3: Every operation that writes back, shifts and rotates included, sets the flag at the next clock edge to 1 if the written value is 0x00 and to 0 otherwise.
- R4: Code 4 (compare) never raises wr_en. At the next edge it sets the flag to 1 if reg_in equals imm and to 0 if it does not.
- R5: Code 1 with imm equal to 0x00 is a no-operation: wr_en stays 0, illegal stays 0 and the flag keeps its value.
- R6: Code 8 (logical left) and code 10 (arithmetic left) give reg_in shifted left by one, with 0 in bit 0.
- R7: Code 9 (logical right) gives reg_in shifted right by one with 0 in bit 7. Code 11 (arithmetic right) gives reg_in shifted right by one with 1 in bit 7.
- R8: Code 12 (rotate left) moves bit 7 of reg_in into bit 0. Code 13 (rotate right) moves bit 0 into bit 7.
- R9: A shift or rotate code with shift_cnt not equal to 1 is illegal. So is any code outside 0–4 and 8–13. In that case illegal is 1 in that cycle, wr_en is 0 and the flag keeps its value.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| op_valid | input | 1 | An operation is presented this cycle |
| op_sel | input | 4 | Operation code (see requirements) |
| shift_cnt | input | 3 | Shift count field; only 1 is legal |
| reg_in | input | 8 | Register operand |
| imm | input | 8 | Immediate operand |
| wr_data | output | 8 | Value to write back to the register |
| wr_en | output | 1 | Write wr_data back this cycle |
| illegal | output | 1 | Operation rejected this cycle |
| zflag | output | 1 | Zero/equal condition flag |

## Verification
The bench targets the places where a plausible design goes wrong:
- Arithmetic right shift on 0x00 and 0x02 catches a design that copies the sign bit, because it would produce 0x00 and 0x01.
- The no-operation is tested with the flag at 1 on a non-zero register. A design that treats it as an ordinary OR would clear the flag.
- Add cases of 0xFF+0x01 and 0xF0+0x20 expose a design that lets a carry leak or that fails to set the flag on a wrapped zero.
- Rejected shift counts and unassigned codes are issued while the flag is 1. A design that still writes or updates the flag would show a write strobe or a cleared flag.

// File: rtl/imm_alu_unit.sv
module imm_alu_unit #(
  parameter int W    = 8,
  parameter int OPW  = 4,
  parameter int CNTW = 3
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            op_valid,
  input  logic [OPW-1:0]  op_sel,
  input  logic [CNTW-1:0] shift_cnt,
  input  logic [W-1:0]    reg_in,
  input  logic [W-1:0]    imm,
  output logic [W-1:0]    wr_data,
  output logic            wr_en,
  output logic            illegal,
  output logic            zflag
);
  localparam logic [OPW-1:0] OP_XOR = OPW'(0);
  localparam logic [OPW-1:0] OP_OR  = OPW'(1);
  localparam logic [OPW-1:0] OP_AND = OPW'(2);
  localparam logic [OPW-1:0] OP_ADD = OPW'(3);
  localparam logic [OPW-1:0] OP_CMP = OPW'(4);
  localparam logic [OPW-1:0] OP_SLL = OPW'(8);
  localparam logic [OPW-1:0] OP_SLR = OPW'(9);
  localparam logic [OPW-1:0] OP_SAL = OPW'(10);
  localparam logic [OPW-1:0] OP_SAR = OPW'(11);
  localparam logic [OPW-1:0] OP_ROL = OPW'(12);
  localparam logic [OPW-1:0] OP_ROR = OPW'(13);
  localparam logic [CNTW-1:0] ONE_STEP = CNTW'(1);

  logic [W-1:0] res;
  logic         writes, legal, touch_flag, cmp_eq, is_shift;

  assign is_shift = (op_sel >= OP_SLL) && (op_sel <= OP_ROR);
  assign cmp_eq   = (reg_in == imm);

  always_comb begin
    res        = reg_in;
    writes     = 1'b1;
    legal      = 1'b1;
    touch_flag = 1'b1;
    case (op_sel)
      OP_XOR: res = reg_in ^ imm;
      OP_OR: begin
        res = reg_in | imm;
        if (imm == '0) begin
          writes     = 1'b0;
          touch_flag = 1'b0;
        end
      end
      OP_AND: res = reg_in & imm;
      OP_ADD: res = reg_in + imm;
      OP_CMP: writes = 1'b0;
      OP_SLL, OP_SAL: res = {reg_in[W-2:0], 1'b0};
      OP_SLR: res = {1'b0, reg_in[W-1:1]};
      OP_SAR: res = {1'b1, reg_in[W-1:1]};
      OP_ROL: res = {reg_in[W-2:0], reg_in[W-1]};
      OP_ROR: res = {reg_in[0], reg_in[W-1:1]};
      default: legal = 1'b0;
    endcase
    if (is_shift && shift_cnt != ONE_STEP) legal = 1'b0;
  end

  assign wr_data = res;
  assign wr_en   = op_valid && legal && writes;
  assign illegal = op_valid && !legal;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      zflag <= 1'b0;
    else if (op_valid && legal && touch_flag)
      zflag <= (op_sel == OP_CMP) ? cmp_eq : (res == '0);
  end
endmodule

// File: rtl/imm_alu_unit_chk.sv
module imm_alu_unit_chk #(
  parameter int W    = 8,
  parameter int OPW  = 4,
  parameter int CNTW = 3
) (
  input logic            clk,
  input logic            rst_n,
  input logic            op_valid,
  input logic [OPW-1:0]  op_sel,
  input logic [CNTW-1:0] shift_cnt,
  input logic [W-1:0]    reg_in,
  input logic [W-1:0]    imm,
  input logic [W-1:0]    wr_data,
  input logic            wr_en,
  input logic            illegal,
  input logic            zflag
);
  assert_idle_quiet_R1: assert property (@(posedge clk) disable iff (!rst_n)
    !op_valid |-> (!wr_en && !illegal));

  assert_idle_hold_R1: assert property (@(posedge clk) disable iff (!rst_n)
    !op_valid |=> $stable(zflag));

  assert_add_wrap_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (op_valid && op_sel == OPW'(3)) |-> (wr_en && wr_data == W'(reg_in + imm)));

  assert_write_zero_R3: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |=> (zflag == ($past(wr_data) == '0)));

  assert_cmp_flag_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (op_valid && op_sel == OPW'(4)) |=> (zflag == ($past(reg_in) == $past(imm))));

  assert_cmp_nowrite_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (op_valid && op_sel == OPW'(4)) |-> !wr_en);

  assert_nop_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (op_valid && op_sel == OPW'(1) && imm == '0) |-> (!wr_en && !illegal));

  assert_nop_flag_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (op_valid && op_sel == OPW'(1) && imm == '0) |=> $stable(zflag));

  assert_sar_msb_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (op_valid && op_sel == OPW'(11) && shift_cnt == CNTW'(1)) |-> (wr_en && wr_data[W-1]));

  assert_reject_excl_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !(wr_en && illegal));

  assert_reject_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
    illegal |=> $stable(zflag));
endmodule

bind imm_alu_unit imm_alu_unit_chk #(.W(W), .OPW(OPW), .CNTW(CNTW)) u_chk (
  .clk(clk), .rst_n(rst_n), .op_valid(op_valid), .op_sel(op_sel),
  .shift_cnt(shift_cnt), .reg_in(reg_in), .imm(imm), .wr_data(wr_data),
  .wr_en(wr_en), .illegal(illegal), .zflag(zflag)
);

// File: tb/imm_alu_unit_bench.sv
module imm_alu_unit_bench;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       op_valid = 1'b0;
  logic [3:0] op_sel = '0;
  logic [2:0] shift_cnt = 3'd1;
  logic [7:0] reg_in = '0;
  logic [7:0] imm = '0;
  logic [7:0] wr_data;
  logic       wr_en, illegal, zflag;

  int checks = 0;
  int errors = 0;
  logic [7:0] s_data;
  logic       s_wen, s_ill;

  always #10 clk = ~clk;

  imm_alu_unit u_imm_alu_unit (
    .clk(clk), .rst_n(rst_n), .op_valid(op_valid), .op_sel(op_sel),
    .shift_cnt(shift_cnt), .reg_in(reg_in), .imm(imm), .wr_data(wr_data),
    .wr_en(wr_en), .illegal(illegal), .zflag(zflag)
  );

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  task automatic run_op(input logic [3:0] op, input logic [2:0] cnt,
                        input logic [7:0] r, input logic [7:0] i);
    @(negedge clk);
    op_valid = 1'b1; op_sel = op; shift_cnt = cnt; reg_in = r; imm = i;
    #2;
    s_data = wr_data; s_wen = wr_en; s_ill = illegal;
    @(negedge clk);
    op_valid = 1'b0;
    #2;
  endtask

  task automatic test_reset();
    chk("R1 reset flag", zflag, 0);
    chk("R1 idle wr_en", wr_en, 0);
    chk("R1 idle illegal", illegal, 0);
  endtask

  task automatic test_logic_ops();
    run_op(4'd0, 3'd1, 8'h5A, 8'hFF);
    chk("R2 xor data", s_data, 8'hA5); chk("R2 xor wr_en", s_wen, 1);
    chk("R3 xor nonzero flag", zflag, 0);
    run_op(4'd0, 3'd1, 8'h3C, 8'h3C);
    chk("R3 xor zero flag", zflag, 1);
    run_op(4'd1, 3'd1, 8'h10, 8'h01);
    chk("R2 or data", s_data, 8'h11); chk("R3 or flag", zflag, 0);
    run_op(4'd2, 3'd1, 8'hF0, 8'h0F);
    chk("R2 and data", s_data, 8'h00); chk("R3 and zero flag", zflag, 1);
  endtask

  task automatic test_add();
    run_op(4'd3, 3'd1, 8'hF0, 8'h20);
    chk("R2 add wrap data", s_data, 8'h10); chk("R3 add flag", zflag, 0);
    run_op(4'd3, 3'd1, 8'hFF, 8'h01);
    chk("R2 add wrap to zero", s_data, 8'h00); chk("R3 add zero flag", zflag, 1);
    run_op(4'd3, 3'd7, 8'h12, 8'h34);
    chk("R2 add ignores count", s_data, 8'h46); chk("R2 add wr_en", s_wen, 1);
  endtask

  task automatic test_compare();
    run_op(4'd4, 3'd1, 8'h42, 8'h42);
    chk("R4 cmp eq wr_en", s_wen, 0); chk("R4 cmp eq flag", zflag, 1);
    run_op(4'd4, 3'd1, 8'h42, 8'h43);
    chk("R4 cmp ne wr_en", s_wen, 0); chk("R4 cmp ne flag", zflag, 0);
  endtask

  task automatic test_nop();
    run_op(4'd4, 3'd1, 8'h07, 8'h07);
    run_op(4'd1, 3'd1, 8'h55, 8'h00);
    chk("R5 nop wr_en", s_wen, 0); chk("R5 nop illegal", s_ill, 0);
    chk("R5 nop keeps flag 1", zflag, 1);
    run_op(4'd4, 3'd1, 8'h07, 8'h08);
    run_op(4'd1, 3'd1, 8'h00, 8'h00);
    chk("R5 nop keeps flag 0", zflag, 0);
  endtask

  task automatic test_shifts();
    run_op(4'd8, 3'd1, 8'h81, 8'h00);
    chk("R6 sll data", s_data, 8'h02); chk("R6 sll wr_en", s_wen, 1);
    run_op(4'd10, 3'd1, 8'h81, 8'h00);
    chk("R6 sal data", s_data, 8'h02);
    run_op(4'd8, 3'd1, 8'h80, 8'h00);
    chk("R3 sll to zero flag", zflag, 1);
    run_op(4'd9, 3'd1, 8'h81, 8'h00);
    chk("R7 slr data", s_data, 8'h40); chk("R3 slr flag", zflag, 0);
    run_op(4'd11, 3'd1, 8'h02, 8'h00);
    chk("R7 sar data", s_data, 8'h81);
    run_op(4'd11, 3'd1, 8'h00, 8'h00);
    chk("R7 sar of zero", s_data, 8'h80);
    run_op(4'd12, 3'd1, 8'h81, 8'h00);
    chk("R8 rol data", s_data, 8'h03);
    run_op(4'd13, 3'd1, 8'h81, 8'h00);
    chk("R8 ror data", s_data, 8'hC0);
  endtask

  task automatic test_reject();
    run_op(4'd4, 3'd1, 8'h11, 8'h11);
    run_op(4'd9, 3'd2, 8'h01, 8'h00);
    chk("R9 count 2 illegal", s_ill, 1); chk("R9 count 2 wr_en", s_wen, 0);
    chk("R9 count 2 flag", zflag, 1);
    run_op(4'd12, 3'd0, 8'h00, 8'h00);
    chk("R9 count 0 illegal", s_ill, 1);
    run_op(4'd7, 3'd1, 8'h01, 8'h01);
    chk("R9 code 7 illegal", s_ill, 1); chk("R9 code 7 wr_en", s_wen, 0);
    run_op(4'd15, 3'd1, 8'h01, 8'h01);
    chk("R9 code 15 illegal", s_ill, 1); chk("R9 flag held", zflag, 1);
  endtask

  task automatic test_idle();
    @(negedge clk);
    op_sel = 4'd0; reg_in = 8'h01; imm = 8'h02;
    repeat (3) @(negedge clk);
    #2;
    chk("R1 idle flag held", zflag, 1);
    chk("R1 idle no write", wr_en, 0);
  endtask

  initial begin
    #1;
    test_reset();
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    test_reset();
    test_logic_ops();
    test_add();
    test_compare();
    test_nop();
    test_shifts();
    test_reject();
    test_idle();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #(200000 * 20);
    checks++; errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule